// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral guards a chip against runaway software. Software programs a timeout in half-second steps and starts a down-counter. The counter is paced by a half-second tick strobe. Software keeps the system alive by writing a two-word key to the service register. If the count reaches zero, the block records the cause and drives a reset. The reset goes either to the chip internally or only to the external reset pin, as configured. Once started, the timer cannot be stopped.

A pre-timeout interrupt can warn software a programmable number of half-seconds before expiry. Software can also request an internal reset directly, or hold the external reset pin low. After power-up, a power-down counter runs. It pulses the external reset pin low for one clock unless software disarms it. A cause register tells software why the last reset happened. Only a power-on reset clears it, so it survives the reset that the watchdog itself provokes.

Registers are 16 bits wide on a simple write-strobe bus with a combinational read port. The register offsets are: control 0x0, service 0x2, cause 0x4, interrupt control 0x6 and power-down control 0x8.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, control reads 0x0030, cause reads 0x0000, interrupt control reads 0x0000 and power-down control reads 0x0001; `int_rst_o`=0, `ext_rst_n`=1 and `irq_o`=0.
- R2: Writing 1 to control bit 2 starts the timer. Later writes of 0 to that bit leave it set and the count running.
- R3: Control bit 0 (suspend in low power) takes its value from the first control write after reset only. Later writes leave it unchanged.
- R4: Starting the timer loads the count with T+1, where T is control bits 15:8. Each tick decrements the count. The cycle after the count reaches 0, cause bit 1 is set. One cycle later the reset output is driven, and it stays asserted until reset.
- R5: With control bit 3 = 0, expiry asserts `int_rst_o`. With bit 3 = 1, expiry pulls `ext_rst_n` low and leaves `int_rst_o` at 0.
- R6: A write of 0x5555 followed by a write of 0xAAAA to the service register reloads the count to T+1. Any other value or order, including 0xAAAA alone, leaves the count untouched.
- R7: Changing T while running does not alter the current count. The new value is used from the next valid refresh.
- R8: The pre-timeout status is interrupt-control bit 14. It is set by the tick that brings the running count down to the margin in bits 7:0. Writing 1 to bit 14 clears it. `irq_o` equals bit 14 AND enable bit 15.
- R9: Writing control bit 4 as 0 gives a one-cycle `int_rst_o` pulse and sets cause bit 0 (clearing cause bit 1). Bit 4 always reads 1.
- R10: While control bit 5 is 0, `ext_rst_n` is low.
- R11: The cause register keeps its value through `rst_n`. Only `por_n` clears it.
- R12: The power-down counter is armed after reset. On the PD_TICKS-th tick, `ext_rst_n` goes low for exactly one clock, unless 0 was first written to the power-down control register. Bit 0 of that register reads 1 while the counter is armed.
- R13: With suspend bit 0 set and `lp_i` high, ticks do not decrement the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| rst_n | input | 1 | System reset, active low; keeps the cause register |
| tick_i | input | 1 | One-clock strobe every half second |
| lp_i | input | 1 | Chip is in low-power mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Pre-timeout interrupt |
| int_rst_o | output | 1 | Internal chip reset request, active high |
| ext_rst_n | output | 1 | External reset pin, active low |

## Verification
The properties take for granted that `tick_i` is a single-clock strobe and that each bus write lasts one clock. They also assume that only a bus write can raise the count, so any increase must follow a write cycle. The stimulus drives ticks and writes in separate clocks, always one clock wide. It never ticks in the same cycle as a service or control write. Counts and margins are kept small, so every expiry and interrupt lands in a known cycle.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int WTW      = 8,
  parameter int PD_TICKS = 64
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        lp_i,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  output logic        int_rst_o,
  output logic        ext_rst_n
);
  localparam int CW  = WTW + 1;
  localparam int PDW = $clog2(PD_TICKS + 1);

  logic core_rst_n;
  assign core_rst_n = rst_n & por_n;

  logic [WTW-1:0] wt_q, wict_q;
  logic wda_q, wre_q, wde_q, zst_q, zst_lock;
  logic key_q, tmo_q, tmo_drv, swr_q;
  logic wie_q, wtis_q;
  logic pd_en, pd_pulse;
  logic [PDW-1:0] pd_cnt;
  logic st_tout, st_swr;
  logic [CW-1:0] cnt;

  wire wr_ctrl = bus_wr && bus_addr == 4'h0;
  wire wr_svc  = bus_wr && bus_addr == 4'h2;
  wire wr_icr  = bus_wr && bus_addr == 4'h6;
  wire wr_misc = bus_wr && bus_addr == 4'h8;

  wire [CW-1:0] ld_cur = CW'(wt_q) + CW'(1);
  wire [CW-1:0] ld_new = CW'(bus_wdata[8 +: WTW]) + CW'(1);
  wire start   = wr_ctrl && bus_wdata[2] && !wde_q;
  wire refresh = wr_svc && bus_wdata == 16'hAAAA && key_q;
  wire run     = wde_q && !(zst_q && lp_i);
  wire dec     = run && tick_i && cnt != '0;
  wire hit     = wde_q && cnt == '0 && !tmo_q;
  wire swreq   = wr_ctrl && !bus_wdata[4];
  wire pre_hit = dec && (cnt - CW'(1)) == CW'(wict_q);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wt_q <= '0; wda_q <= 1'b1; wre_q <= 1'b0; wde_q <= 1'b0;
      zst_q <= 1'b0; zst_lock <= 1'b0;
    end else if (wr_ctrl) begin
      wt_q  <= bus_wdata[8 +: WTW];
      wda_q <= bus_wdata[5];
      wre_q <= bus_wdata[3];
      wde_q <= wde_q | bus_wdata[2];
      if (!zst_lock) begin
        zst_q    <= bus_wdata[0];
        zst_lock <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) key_q <= 1'b0;
    else if (wr_svc) key_q <= bus_wdata == 16'h5555;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  cnt <= '0;
    else if (start)   cnt <= ld_new;
    else if (refresh) cnt <= ld_cur;
    else if (dec)     cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      tmo_q <= 1'b0; tmo_drv <= 1'b0; swr_q <= 1'b0;
    end else begin
      if (hit) tmo_q <= 1'b1;
      tmo_drv <= tmo_q;
      swr_q   <= swreq;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wie_q <= 1'b0; wtis_q <= 1'b0; wict_q <= '0;
    end else begin
      if (wr_icr) begin
        wie_q  <= bus_wdata[15];
        wict_q <= bus_wdata[WTW-1:0];
      end
      if (pre_hit) wtis_q <= 1'b1;
      else if (wr_icr && bus_wdata[14]) wtis_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pd_en <= 1'b1; pd_cnt <= '0; pd_pulse <= 1'b0;
    end else begin
      pd_pulse <= 1'b0;
      if (wr_misc && bus_wdata == 16'h0000) pd_en <= 1'b0;
      else if (pd_en && tick_i) begin
        if (pd_cnt == PDW'(PD_TICKS - 1)) begin
          pd_pulse <= 1'b1;
          pd_en    <= 1'b0;
        end else pd_cnt <= pd_cnt + PDW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_tout <= 1'b0; st_swr <= 1'b0;
    end else if (hit) begin
      st_tout <= 1'b1; st_swr <= 1'b0;
    end else if (swreq && !tmo_q) begin
      st_tout <= 1'b0; st_swr <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = (16'(wt_q) << 8) |
                           16'({2'b00, wda_q, 1'b1, wre_q, wde_q, 1'b0, zst_q});
      4'h4:    bus_rdata = {14'd0, st_tout, st_swr};
      4'h6:    bus_rdata = {wie_q, wtis_q, 14'd0} | 16'(wict_q);
      4'h8:    bus_rdata = {15'd0, pd_en};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq_o     = wie_q && wtis_q;
  assign int_rst_o = (tmo_drv && !wre_q) || swr_q;
  assign ext_rst_n = !(!wda_q || (tmo_drv && wre_q) || pd_pulse);
endmodule

module wdog_keyed_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          wde_q,
  input logic          tmo_drv,
  input logic          st_tout,
  input logic          swr_q,
  input logic          wtis_q,
  input logic          pd_en,
  input logic          pd_pulse,
  input logic [CW-1:0] cnt
);
  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wde_q |=> wde_q);
  // R4
  cause_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_drv |-> st_tout);
  // R6
  reload_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(bus_wr));
  // R8
  pre_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wtis_q) |-> wde_q);
  // R9
  swr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr_q |-> $past(bus_wr));
  // R12
  pd_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_pulse) |-> $past(pd_en));
  // R12
  pd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse |=> !pd_pulse);
endmodule

bind wdog_keyed wdog_keyed_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .bus_wr(bus_wr), .wde_q(wde_q),
  .tmo_drv(tmo_drv), .st_tout(st_tout), .swr_q(swr_q), .wtis_q(wtis_q),
  .pd_en(pd_en), .pd_pulse(pd_pulse), .cnt(cnt)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, tick_i = 1'b0, lp_i = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic irq_o, int_rst_o, ext_rst_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_req = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wdog_keyed #(.WTW(8), .PD_TICKS(6)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_i(tick_i), .lp_i(lp_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .int_rst_o(int_rst_o),
    .ext_rst_n(ext_rst_n)
  );

  always begin
    @(posedge clk); #1;
    if (rd_req && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk); bus_addr = a; exp_q.push_back(e); tag_q.push_back(t); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s pin act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic sys_rst();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(4'h8, 16'h0000);
  endtask

  task automatic finish_up();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all watchdog act=hung exp=finished");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 16'h0030, "R1");
    rd(4'h4, 16'h0000, "R1");
    rd(4'h6, 16'h0000, "R1");
    rd(4'h8, 16'h0001, "R1");
    chk("R1 int", int_rst_o, 0); chk("R1 ext", ext_rst_n, 1); chk("R1 irq", irq_o, 0);

    // R12 armed power-down pulse
    for (int i = 0; i < 5; i++) begin tk(); chk("R12 early", ext_rst_n, 1); end
    tk(); chk("R12 pulse", ext_rst_n, 0);
    @(negedge clk); chk("R12 one clock", ext_rst_n, 1);
    rd(4'h8, 16'h0000, "R12");
    // R12 disarmed
    sys_rst();
    for (int i = 0; i < 7; i++) begin tk(); chk("R12 disarmed", ext_rst_n, 1); end

    // R2 R3 R4 start, sticky enable, expiry ordering
    wr(4'h0, 16'h0234);
    rd(4'h0, 16'h0234, "R2");
    wr(4'h0, 16'h0231);
    rd(4'h0, 16'h0234, "R3");
    @(negedge clk); bus_addr = 4'h4;
    tk(); tk(); chk("R4 not yet", int_rst_o, 0);
    tk(); chk("R4 cause pre", bus_rdata, 16'h0000); chk("R4 int pre", int_rst_o, 0);
    @(negedge clk); chk("R4 cause set", bus_rdata, 16'h0002); chk("R4 int still 0", int_rst_o, 0);
    @(negedge clk); chk("R4 int reset", int_rst_o, 1);
    repeat (3) @(negedge clk); chk("R4 held", int_rst_o, 1);

    // R11 cause survives system reset
    sys_rst();
    rd(4'h4, 16'h0002, "R11");
    chk("R11 int cleared", int_rst_o, 0);

    // R6 key sequence
    wr(4'h0, 16'h0334);
    tk(); tk(); tk();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tk(); tk(); tk();
    repeat (2) @(negedge clk); chk("R6 refreshed", int_rst_o, 0);
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tk(); repeat (2) @(negedge clk); chk("R6 bad keys ignored", int_rst_o, 1);

    // R7 timeout change not immediate
    sys_rst();
    wr(4'h0, 16'h0134); wr(4'h0, 16'h0534);
    tk(); tk(); repeat (2) @(negedge clk); chk("R7 old count", int_rst_o, 1);
    sys_rst();
    wr(4'h0, 16'h0134); wr(4'h0, 16'h0534);
    tk();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    for (int i = 0; i < 5; i++) tk();
    repeat (2) @(negedge clk); chk("R7 new count alive", int_rst_o, 0);
    tk(); repeat (2) @(negedge clk); chk("R7 new count expiry", int_rst_o, 1);

    // R5 external-only action
    sys_rst();
    wr(4'h0, 16'h003C);
    tk(); repeat (2) @(negedge clk);
    chk("R5 ext", ext_rst_n, 0); chk("R5 int", int_rst_o, 0);

    // R8 pre-timeout
    sys_rst();
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0434);
    tk(); tk(); chk("R8 before margin", irq_o, 0);
    tk(); chk("R8 irq", irq_o, 1);
    rd(4'h6, 16'hC002, "R8");
    wr(4'h6, 16'hC002); chk("R8 cleared", irq_o, 0);

    // R9 software reset
    sys_rst();
    wr(4'h0, 16'h0020); chk("R9 pulse", int_rst_o, 1);
    @(negedge clk); chk("R9 one cycle", int_rst_o, 0);
    rd(4'h4, 16'h0001, "R9");
    rd(4'h0, 16'h0030, "R9");

    // R10 external pin control
    wr(4'h0, 16'h0010); chk("R10 low", ext_rst_n, 0);
    wr(4'h0, 16'h0030); chk("R10 high", ext_rst_n, 1);

    // R13 low-power suspend, R3 lock to 1
    sys_rst();
    wr(4'h0, 16'h0135);
    lp_i = 1'b1;
    tk(); tk(); repeat (2) @(negedge clk); chk("R13 suspended", int_rst_o, 0);
    wr(4'h0, 16'h0134);
    rd(4'h0, 16'h0135, "R3");
    lp_i = 1'b0;
    tk(); tk(); repeat (2) @(negedge clk); chk("R13 resumes", int_rst_o, 1);

    // R11 power-on clears cause
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    rd(4'h4, 16'h0000, "R11");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule